// File: doc/BRIEF.md
# Dual-Mode Pixel Input Formatter

This block sits between a graphics controller and the link encoders of a display transmitter. It takes pixel data in one of two bus formats and turns it into one full 24-bit pixel per clock, together with data enable, horizontal sync, vertical sync and two control bits. A bus-width strap selects the format. In the wide format a 24-bit word is sampled once per clock on the rising edge. In the narrow format a 12-bit word is sampled on both edges, and the two halves are joined into one pixel.

Three shared pins change their meaning with two strap inputs. They can be two control bits sent during blanking, or a 3-bit capture-delay code, or the low three bits of a serial-bus slave address. In the narrow format the eight top bits of the input bus carry no pixel data. Their state is latched into a configuration byte that a host can read back. The output stage is registered and has a valid strobe. The latency is the same in both bus formats.

Top module: `pixfmt_top`

## Requirements
- R1: With `wide_mode`=1, `data_in[23:0]` sampled at rising edge t appears on `pix_out` right after rising edge t+1+D. D is the active delay code (0 unless R6 applies).
- R2: With `wide_mode`=0, `data_in[11:0]` at rising edge t gives pixel bits [11:0]. `data_in[11:0]` at the next falling edge gives bits [23:12]. The pixel appears with the same latency as in R1.
- R3: With `wide_mode`=0, `cfg_byte` takes the value of `data_in[23:16]` one rising edge after it is sampled. With `wide_mode`=1, `cfg_byte` holds its value.
- R4: When `de_out`=1, `pix_out` carries the pixel and `ctl_out`=0. When `de_out`=0, `pix_out`=0 and `ctl_out` carries the control bits. `de_out`, `hs_out` and `vs_out` follow `de_in`, `hs_in` and `vs_in` with the same latency as the pixel.
- R5: With `serial_en`=0 and `deskew_en`=0, the control bits are `ctl[1]`=`mf_in[1]` and `ctl[0]`=`mf_in[0]`. `mf_in[2]` has no effect on any output. `dk_code`=0 and `addr_lsb`=0.
- R6: With `serial_en`=0 and `deskew_en`=1, `dk_code`=`mf_in` (bit 2 most significant). The pixel, enable, sync and valid outputs are all delayed by `dk_code` more cycles. The control bits are 0 and `addr_lsb`=0.
- R7: With `serial_en`=1, `addr_lsb`=`mf_in`, the control bits are 0 and `dk_code`=0, whatever `deskew_en` is.
- R8: `vld_out` is 0 after reset. It rises right after the (1+D)-th rising edge that follows reset release, and it then stays high.
- R9: While `rst_n`=0 at a rising edge, `pix_out`, `cfg_byte`, `ctl_out`, `de_out`, `hs_out`, `vs_out` and `vld_out` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges are used in narrow format |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: 24-bit single-edge; 0: 12-bit dual-edge |
| serial_en | input | 1 | Strap: shared pins give address bits |
| deskew_en | input | 1 | Strap: shared pins give the delay code |
| data_in | input | 24 | Pixel input bus |
| de_in | input | 1 | Data enable |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| mf_in | input | 3 | Shared multifunction pins |
| pix_out | output | 24 | Assembled pixel, zero in blanking |
| de_out | output | 1 | Delayed data enable |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| ctl_out | output | 2 | Control bits during blanking |
| vld_out | output | 1 | Output valid strobe |
| cfg_byte | output | 8 | Latched configuration byte |
| addr_lsb | output | 3 | Low slave-address bits |
| dk_code | output | 3 | Active capture-delay code |

## Verification
A wrong falling-edge half or a stale mode flag shows up as a corrupted upper 12 bits of `pix_out`, one rising edge after capture plus the delay code. A wrong tap selection moves every output field by whole cycles, and the beat-indexed comparison catches that on the first checked beat. A strap decode error shows at once on `addr_lsb` and `dk_code`, and on `ctl_out` in the first blanking beat that comes out. A configuration latch that runs in the wrong mode changes `cfg_byte` one edge after the unwanted sample.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int PIX_W  = 24;
  localparam int HALF_W = PIX_W / 2;
  localparam int CFG_W  = 8;
  localparam int MF_W   = 3;
  localparam int CTL_W  = 2;

  typedef struct packed {
    logic              vld;
    logic              de;
    logic              hs;
    logic              vs;
    logic [CTL_W-1:0]  ctl;
    logic [PIX_W-1:0]  pix;
  } beat_t;

  typedef struct packed {
    logic [CTL_W-1:0] ctl;
    logic [MF_W-1:0]  dk;
    logic [MF_W-1:0]  addr;
  } strap_t;

  // the first-captured half is the low half of the pixel
  function automatic logic [PIX_W-1:0] join_halves(
    input logic [HALF_W-1:0] first_half,
    input logic [HALF_W-1:0] second_half);
    return {second_half, first_half};
  endfunction

  function automatic strap_t decode_strap(
    input logic            ser,
    input logic            dsk,
    input logic [MF_W-1:0] mf);
    strap_t s;
    s = '0;
    if (ser)      s.addr = mf;
    else if (dsk) s.dk   = mf;
    else          s.ctl  = mf[CTL_W-1:0];
    return s;
  endfunction

  // blanking replaces the pixel; active video silences the control bits
  function automatic beat_t shape_output(input beat_t b);
    beat_t o;
    o = b;
    if (b.de) o.ctl = '0;
    else      o.pix = '0;
    return o;
  endfunction
endpackage

// File: rtl/pf_strap_decode.sv
module pf_strap_decode
  import pf_pkg::*;
(
  input  logic            serial_en,
  input  logic            deskew_en,
  input  logic [MF_W-1:0] mf_in,
  output logic [CTL_W-1:0] ctl,
  output logic [MF_W-1:0]  dk,
  output logic [MF_W-1:0]  addr
);
  strap_t dec;

  always_comb begin
    dec  = decode_strap(serial_en, deskew_en, mf_in);
    ctl  = dec.ctl;
    dk   = dec.dk;
    addr = dec.addr;
  end
endmodule

// File: rtl/pf_capture.sv
module pf_capture
  import pf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic [PIX_W-1:0]  data_in,
  input  logic              de_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic [CTL_W-1:0]  ctl_in,
  output beat_t             beat,
  output logic [CFG_W-1:0]  cfg
);
  logic [HALF_W-1:0] lo_q;
  logic [HALF_W-1:0] hi_wide_q;
  logic [HALF_W-1:0] hi_fall_q;
  logic              wide_q;
  logic              vld_q, de_q, hs_q, vs_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [CFG_W-1:0]  cfg_q;
  logic [HALF_W-1:0] hi_sel;
  logic              cfg_load;

  assign cfg_load = !wide_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      hi_wide_q <= '0;
      wide_q    <= 1'b0;
      vld_q     <= 1'b0;
      de_q      <= 1'b0;
      hs_q      <= 1'b0;
      vs_q      <= 1'b0;
      ctl_q     <= '0;
      cfg_q     <= '0;
    end else begin
      lo_q      <= data_in[HALF_W-1:0];
      hi_wide_q <= data_in[PIX_W-1:HALF_W];
      wide_q    <= wide_mode;
      vld_q     <= 1'b1;
      de_q      <= de_in;
      hs_q      <= hs_in;
      vs_q      <= vs_in;
      ctl_q     <= ctl_in;
      if (cfg_load) cfg_q <= data_in[PIX_W-1:PIX_W-CFG_W];
    end
  end

  // second half of a narrow-format pixel arrives on the falling edge
  always_ff @(negedge clk) begin
    if (!rst_n) hi_fall_q <= '0;
    else        hi_fall_q <= data_in[HALF_W-1:0];
  end

  assign hi_sel = wide_q ? hi_wide_q : hi_fall_q;

  always_comb begin
    beat.vld = vld_q;
    beat.de  = de_q;
    beat.hs  = hs_q;
    beat.vs  = vs_q;
    beat.ctl = ctl_q;
    beat.pix = join_halves(lo_q, hi_sel);
  end

  assign cfg = cfg_q;

  // R3: narrow format loads the top input byte into the configuration byte
  a_r3_cfg_follow: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wide_mode)) |-> (cfg == $past(data_in[PIX_W-1:PIX_W-CFG_W])));

  // R3: wide format leaves the configuration byte alone
  a_r3_cfg_hold_wide: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wide_mode)) |-> $stable(cfg));
endmodule

// File: rtl/pf_deskew.sv
module pf_deskew
  import pf_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NTAP = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  beat_t            beat_in,
  input  logic [SEL_W-1:0] sel,
  output beat_t            beat_out
);
  beat_t taps [NTAP];

  assign taps[0] = beat_in;

  generate
    if (NTAP > 1) begin : g_line
      beat_t line_q [1:NTAP-1];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 1; k < NTAP; k++) line_q[k] <= '0;
        end else begin
          line_q[1] <= beat_in;
          for (int k = 2; k < NTAP; k++) line_q[k] <= line_q[k-1];
        end
      end
      for (genvar g = 1; g < NTAP; g++) begin : g_tap
        assign taps[g] = line_q[g];
      end
    end
  endgenerate

  assign beat_out = taps[sel];
endmodule

// File: rtl/pixfmt_top.sv
module pixfmt_top
  import pf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic              serial_en,
  input  logic              deskew_en,
  input  logic [PIX_W-1:0]  data_in,
  input  logic              de_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic [MF_W-1:0]   mf_in,
  output logic [PIX_W-1:0]  pix_out,
  output logic              de_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic [CTL_W-1:0]  ctl_out,
  output logic              vld_out,
  output logic [CFG_W-1:0]  cfg_byte,
  output logic [MF_W-1:0]   addr_lsb,
  output logic [MF_W-1:0]   dk_code
);
  logic [CTL_W-1:0] strap_ctl;
  logic [MF_W-1:0]  strap_dk;
  logic [MF_W-1:0]  strap_addr;
  beat_t            cap_beat;
  beat_t            tap_beat;
  beat_t            shaped;
  beat_t            out_q;

  pf_strap_decode u_dec (
    .serial_en (serial_en),
    .deskew_en (deskew_en),
    .mf_in     (mf_in),
    .ctl       (strap_ctl),
    .dk        (strap_dk),
    .addr      (strap_addr)
  );

  pf_capture u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .wide_mode (wide_mode),
    .data_in   (data_in),
    .de_in     (de_in),
    .hs_in     (hs_in),
    .vs_in     (vs_in),
    .ctl_in    (strap_ctl),
    .beat      (cap_beat),
    .cfg       (cfg_byte)
  );

  pf_deskew #(.SEL_W(MF_W)) u_dsk (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_in  (cap_beat),
    .sel      (strap_dk),
    .beat_out (tap_beat)
  );

  assign shaped = shape_output(tap_beat);

  always_ff @(posedge clk) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= shaped;
  end

  assign pix_out  = out_q.pix;
  assign de_out   = out_q.de;
  assign hs_out   = out_q.hs;
  assign vs_out   = out_q.vs;
  assign ctl_out  = out_q.ctl;
  assign vld_out  = out_q.vld;
  assign addr_lsb = strap_addr;
  assign dk_code  = strap_dk;

  // R4: control bits are silent during active video
  a_r4_ctl_quiet_active: assert property (@(posedge clk) disable iff (!rst_n)
    de_out |-> (ctl_out == '0));

  // R7: serial-bus strap keeps the captured control bits at zero
  a_r7_serial_ctl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(serial_en)) |-> (cap_beat.ctl == '0));

  // R8: once valid, the strobe stays high
  a_r8_vld_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    vld_out |=> vld_out);

  // R9: reset leaves the output cleared
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pix_out == '0 && !vld_out && cfg_byte == '0 && ctl_out == '0));
endmodule

// File: tb/test_pixfmt_top.sv
module test_pixfmt_top;
  localparam int CLK_P = 10;
  localparam int NB    = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b1;
  logic        serial_en = 1'b0;
  logic        deskew_en = 1'b0;
  logic [23:0] data_in = '0;
  logic        de_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic [2:0]  mf_in = '0;
  logic [23:0] pix_out;
  logic        de_out, hs_out, vs_out, vld_out;
  logic [1:0]  ctl_out;
  logic [7:0]  cfg_byte;
  logic [2:0]  addr_lsb, dk_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] b_pix [NB];
  logic        b_de [NB], b_hs [NB], b_vs [NB];
  logic [7:0]  b_cfg [NB];

  pixfmt_top i_pixfmt_top (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .serial_en(serial_en),
    .deskew_en(deskew_en), .data_in(data_in), .de_in(de_in), .hs_in(hs_in),
    .vs_in(vs_in), .mf_in(mf_in), .pix_out(pix_out), .de_out(de_out),
    .hs_out(hs_out), .vs_out(vs_out), .ctl_out(ctl_out), .vld_out(vld_out),
    .cfg_byte(cfg_byte), .addr_lsb(addr_lsb), .dk_code(dk_code)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench view of the strap rules (R5, R6, R7)
  function automatic logic [2:0] exp_dk(input logic ser, input logic dsk, input logic [2:0] mf);
    return (!ser && dsk) ? mf : 3'd0;
  endfunction
  function automatic logic [2:0] exp_addr(input logic ser, input logic [2:0] mf);
    return ser ? mf : 3'd0;
  endfunction
  function automatic logic [1:0] exp_ctl(input logic ser, input logic dsk, input logic [2:0] mf);
    return (ser || dsk) ? 2'd0 : {mf[1], mf[0]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mf_in = '0;
    repeat (2) @(posedge clk);
    #2;
    // R9: cleared state
    chk(pix_out == '0, "R9 pix", {8'd0, pix_out}, 0);
    chk(cfg_byte == '0 && vld_out == 1'b0, "R9 cfg/vld", {23'd0, vld_out, cfg_byte}, 0);
    chk(ctl_out == '0 && !de_out && !hs_out && !vs_out, "R9 ctl/sync",
        {28'd0, ctl_out, hs_out, vs_out}, 0);
  endtask

  task automatic burst(input bit wide, input bit ser, input bit dsk, input logic [2:0] mf);
    logic [2:0]  d;
    logic [1:0]  ec;
    logic [7:0]  ecfg;
    wide_mode = wide;
    serial_en = ser;
    deskew_en = dsk;
    do_reset();
    mf_in = mf;
    d  = exp_dk(ser, dsk, mf);
    ec = exp_ctl(ser, dsk, mf);
    ecfg = 8'd0;
    for (int k = 0; k < NB; k++) begin
      b_pix[k] = 24'($urandom);
      b_de[k]  = 1'($urandom);
      b_hs[k]  = 1'($urandom);
      b_vs[k]  = 1'($urandom);
      b_cfg[k] = 8'($urandom);
    end
    for (int i = 0; i < NB; i++) begin
      @(negedge clk);
      #1;
      rst_n = 1'b1;
      de_in = b_de[i];
      hs_in = b_hs[i];
      vs_in = b_vs[i];
      if (wide) data_in = b_pix[i];
      else      data_in = {b_cfg[i], 4'($urandom), b_pix[i][11:0]};
      @(posedge clk);
      #1;
      if (!wide) data_in[11:0] = b_pix[i][23:12];
      #1;
      if (!wide) ecfg = b_cfg[i];
      // R3: configuration byte follows the top byte in narrow format, holds in wide
      chk(cfg_byte == ecfg, "R3 cfg", {24'd0, cfg_byte}, {24'd0, ecfg});
      // R5 R6 R7: decoded strap outputs
      chk(dk_code == d && addr_lsb == exp_addr(ser, mf), "R7 R6 R5 strap",
          {26'd0, dk_code, addr_lsb}, {26'd0, d, exp_addr(ser, mf)});
      begin
        int j;
        j = i - 1 - int'(d);
        if (j < 0) begin
          // R8: not yet valid
          chk(vld_out == 1'b0, "R8 vld low", {31'd0, vld_out}, 0);
        end else begin
          logic [23:0] ep;
          logic [1:0]  ecc;
          ep  = b_de[j] ? b_pix[j] : 24'd0;
          ecc = b_de[j] ? 2'd0 : ec;
          chk(vld_out == 1'b1, "R8 vld high", {31'd0, vld_out}, 1);
          // R1 (wide) / R2 (narrow) pixel, R6 delay, R4 blanking
          chk(pix_out == ep, wide ? "R1 R4 R6 pixel" : "R2 R4 R6 pixel",
              {8'd0, pix_out}, {8'd0, ep});
          chk(de_out == b_de[j] && hs_out == b_hs[j] && vs_out == b_vs[j],
              "R4 sync", {29'd0, de_out, hs_out, vs_out},
              {29'd0, b_de[j], b_hs[j], b_vs[j]});
          // R5: ignored pin, R7: zero control bits with serial strap
          chk(ctl_out == ecc, "R4 R5 R7 ctl", {30'd0, ctl_out}, {30'd0, ecc});
        end
      end
    end
    @(negedge clk);
    mf_in = '0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    burst(1'b1, 1'b0, 1'b0, 3'b101);  // R1 R5: pin 2 set but ignored
    burst(1'b0, 1'b0, 1'b0, 3'b110);  // R2 R5
    burst(1'b1, 1'b0, 1'b1, 3'b111);  // R6 deepest delay
    burst(1'b0, 1'b0, 1'b1, 3'b011);  // R6 narrow
    burst(1'b0, 1'b1, 1'b1, 3'b101);  // R7 overrides deskew
    burst(1'b1, 1'b1, 1'b0, 3'b010);  // R7 wide, R3 hold
    for (int r = 0; r < 6; r++) begin
      burst(1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule